// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block holds sixteen 64-bit general-purpose registers. Each register can be read or written at 8, 16, 32 or 64 bits. Every width is a view of the same 64-bit storage, so a value written at full width can be read back through any of its narrower views.

There are two combinational read ports and one write port that is clocked. Each port carries a register index and a size code. A read returns the low bytes of the selected register and fills the rest of the 64 bits with zeros.

A write depends on its destination size:
- A 64-bit write replaces the whole register.
- A 32-bit write replaces the low half and clears the upper half.
- A 16-bit or 8-bit write changes only its own low bits.

Before the merge, the write path widens the source operand. It has its own size code and a sign/zero select, so narrow sources can be zero-extended or sign-extended into wider destinations.

Top module: `pfrf_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all sixteen registers to zero.
- R2: Reads are combinational. The size codes are 4'd1 = byte, 4'd2 = word, 4'd4 = double word and 4'd8 = quad word. A read returns the low 8, 16, 32 or 64 bits of the register with all higher bits zero. Any other size code reads as zero.
- R3: All size views share one 64-bit storage. A quad-word write with a quad-word source stores `wr_data` whole. Its low 32, 16 and 8 bits read back through the narrower codes.
- R4: A double-word destination write stores 32 bits in bits 31:0 and forces bits 63:32 to zero.
- R5: A byte destination write changes only bits 7:0 and keeps bits 63:8. For example, byte 0xAA written into 0x0011223344556677 gives 0x00112233445566AA.
- R6: A word destination write changes only bits 15:0 and keeps bits 63:16. This also holds when the word comes from an extended byte.
- R7: When the source size code is smaller than the destination size code and `wr_sign` is 0, the source is zero-extended. Byte 0xAA to quad word gives 0x00000000000000AA.
- R8: When the source size code is smaller than the destination size code and `wr_sign` is 1, the source's top bit fills the higher bits. Byte 0xAA to quad word gives 0xFFFFFFFFFFFFFFAA.
- R9: A zero-extending double-word to quad-word write leaves the same register value as a plain double-word write of the same data.
- R10: In two cases the write is a plain move of the low destination-width bits of `wr_data`: when the source code is not one of the four valid codes, or when it is not smaller than the destination code.
- R11: A write takes effect at the rising edge, so a read of the same register in the same cycle returns the old value. A write leaves the registers unchanged in two cases: when `wr_en` is 0, or when the destination code is not one of the four valid codes.
- R12: The two read ports are independent. Both may select the same register, or different ones, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_size | input | 4 | Read port 0 size code |
| rd0_data | output | 64 | Read port 0 zero-padded data |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_size | input | 4 | Read port 1 size code |
| rd1_data | output | 64 | Read port 1 zero-padded data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Destination register index |
| wr_dst_size | input | 4 | Destination size code |
| wr_src_size | input | 4 | Source operand size code |
| wr_sign | input | 1 | 1 = sign extension, 0 = zero extension |
| wr_data | input | 64 | Source operand |

## Verification
Read data is due in the same cycle as its index and size. The bench drives inputs one time unit after the falling edge and compares both read ports two units later, ahead of the rising edge, against the model's pre-edge contents. A write becomes visible in the cycle after its rising edge. The model applies the write only after that edge, which also makes every same-cycle read of a written register check the old value. Directed values from the requirements are compared in the same pre-edge slot of the cycle that reads them.

// File: rtl/pfrf_pkg.sv
package pfrf_pkg;

    localparam int XLEN = 64;

    localparam logic [3:0] SZ_BYTE  = 4'd1;
    localparam logic [3:0] SZ_WORD  = 4'd2;
    localparam logic [3:0] SZ_DWORD = 4'd4;
    localparam logic [3:0] SZ_QWORD = 4'd8;

    typedef enum logic {EXT_ZERO = 1'b0, EXT_SIGN = 1'b1} ext_mode_e;

    function automatic logic size_ok(input logic [3:0] s);
        return (s == SZ_BYTE) || (s == SZ_WORD) || (s == SZ_DWORD) || (s == SZ_QWORD);
    endfunction

    function automatic logic [XLEN-1:0] size_mask(input logic [3:0] s);
        logic [XLEN-1:0] m;
        unique case (s)
            SZ_BYTE:  m = XLEN'(64'h0000_0000_0000_00FF);
            SZ_WORD:  m = XLEN'(64'h0000_0000_0000_FFFF);
            SZ_DWORD: m = XLEN'(64'h0000_0000_FFFF_FFFF);
            SZ_QWORD: m = '1;
            default:  m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pfrf_read_align.sv
module pfrf_read_align
    import pfrf_pkg::*;
(
    input  logic [XLEN-1:0] word_i,
    input  logic [3:0]      size_i,
    output logic [XLEN-1:0] data_o
);

    always_comb begin
        unique case (size_i)
            SZ_BYTE:  data_o = {{(XLEN-8){1'b0}},  word_i[7:0]};
            SZ_WORD:  data_o = {{(XLEN-16){1'b0}}, word_i[15:0]};
            SZ_DWORD: data_o = {{(XLEN-32){1'b0}}, word_i[31:0]};
            SZ_QWORD: data_o = word_i;
            default:  data_o = '0;
        endcase
    end

endmodule

// File: rtl/pfrf_ext_unit.sv
module pfrf_ext_unit
    import pfrf_pkg::*;
(
    input  logic [XLEN-1:0] src_data_i,
    input  logic [3:0]      src_size_i,
    input  logic [3:0]      dst_size_i,
    input  logic            sign_i,
    output logic [XLEN-1:0] ext_data_o
);

    logic [3:0]      eff_size;
    logic [XLEN-1:0] keep_mask;
    logic            top_bit;

    // A narrower valid source is widened; anything else is a plain move.
    always_comb begin
        if (size_ok(src_size_i) && (src_size_i < dst_size_i))
            eff_size = src_size_i;
        else
            eff_size = dst_size_i;
    end

    always_comb begin
        keep_mask = size_mask(eff_size);
        unique case (eff_size)
            SZ_BYTE:  top_bit = src_data_i[7];
            SZ_WORD:  top_bit = src_data_i[15];
            SZ_DWORD: top_bit = src_data_i[31];
            default:  top_bit = 1'b0;
        endcase
    end

    always_comb begin
        ext_data_o = src_data_i & keep_mask;
        if ((ext_mode_e'(sign_i) == EXT_SIGN) && top_bit)
            ext_data_o = ext_data_o | ~keep_mask;
    end

endmodule

// File: rtl/pfrf_merge.sv
module pfrf_merge
    import pfrf_pkg::*;
(
    input  logic [XLEN-1:0] old_i,
    input  logic [XLEN-1:0] ext_i,
    input  logic [3:0]      dst_size_i,
    output logic [XLEN-1:0] new_o,
    output logic            dst_ok_o
);

    assign dst_ok_o = size_ok(dst_size_i);

    always_comb begin
        unique case (dst_size_i)
            SZ_BYTE:  new_o = {old_i[XLEN-1:8],  ext_i[7:0]};
            SZ_WORD:  new_o = {old_i[XLEN-1:16], ext_i[15:0]};
            SZ_DWORD: new_o = {{(XLEN-32){1'b0}}, ext_i[31:0]};
            SZ_QWORD: new_o = ext_i;
            default:  new_o = old_i;
        endcase
    end

endmodule

// File: rtl/pfrf_top.sv
module pfrf_top
    import pfrf_pkg::*;
#(
    parameter int NREGS = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [3:0]       rd0_size,
    output logic [XLEN-1:0]  rd0_data,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic [3:0]       rd1_size,
    output logic [XLEN-1:0]  rd1_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [3:0]       wr_dst_size,
    input  logic [3:0]       wr_src_size,
    input  logic             wr_sign,
    input  logic [XLEN-1:0]  wr_data
);

    logic [NREGS-1:0][XLEN-1:0] regs_q;
    logic [XLEN-1:0]            ext_val;
    logic [XLEN-1:0]            merged_val;
    logic                       dst_ok;

    pfrf_ext_unit u_ext (
        .src_data_i (wr_data),
        .src_size_i (wr_src_size),
        .dst_size_i (wr_dst_size),
        .sign_i     (wr_sign),
        .ext_data_o (ext_val)
    );

    pfrf_merge u_merge (
        .old_i      (regs_q[wr_idx]),
        .ext_i      (ext_val),
        .dst_size_i (wr_dst_size),
        .new_o      (merged_val),
        .dst_ok_o   (dst_ok)
    );

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [XLEN-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_en && dst_ok && (wr_idx == IDX_W'(g)))
                q <= merged_val;
        end
        assign regs_q[g] = q;
    end

    pfrf_read_align u_rd0 (
        .word_i (regs_q[rd0_idx]),
        .size_i (rd0_size),
        .data_o (rd0_data)
    );

    pfrf_read_align u_rd1 (
        .word_i (regs_q[rd1_idx]),
        .size_i (rd1_size),
        .data_o (rd1_data)
    );

endmodule

// File: rtl/pfrf_chk.sv
module pfrf_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] rd0_idx,
    input logic [3:0]       rd0_size,
    input logic [63:0]      rd0_data,
    input logic [IDX_W-1:0] rd1_idx,
    input logic [3:0]       rd1_size,
    input logic [63:0]      rd1_data,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [3:0]       wr_dst_size,
    input logic [3:0]       wr_src_size,
    input logic             wr_sign,
    input logic [63:0]      wr_data
);

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd0_data == 64'd0 && rd1_data == 64'd0));

    a_r2_byte_pad: assert property (@(posedge clk) disable iff (rst)
        (rd0_size == 4'd1) |-> (rd0_data[63:8] == 56'd0));

    a_r2_bad_code_zero: assert property (@(posedge clk) disable iff (rst)
        !(rd1_size inside {4'd1, 4'd2, 4'd4, 4'd8}) |-> (rd1_data == 64'd0));

    a_r3_qword_readback: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dst_size == 4'd8 && wr_src_size == 4'd8) |=>
        (rd0_idx != $past(wr_idx) || rd0_size != 4'd8 || rd0_data == $past(wr_data)));

    a_r4_dword_clears_top: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dst_size == 4'd4) |=>
        (rd0_idx != $past(wr_idx) || rd0_size != 4'd8 || rd0_data[63:32] == 32'd0));

    a_r5_byte_keeps_top: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dst_size == 4'd1 && rd1_idx == wr_idx && rd1_size == 4'd8) |=>
        (rd1_idx != $past(rd1_idx) || rd1_size != 4'd8 ||
         rd1_data[63:8] == $past(rd1_data[63:8])));

    a_r8_sign_fill: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dst_size == 4'd8 && wr_src_size == 4'd1 && wr_sign && wr_data[7]) |=>
        (rd0_idx != $past(wr_idx) || rd0_size != 4'd8 || rd0_data[63:8] == {56{1'b1}}));

    a_r12_ports_agree: assert property (@(posedge clk) disable iff (rst)
        (rd0_idx == rd1_idx && rd0_size == rd1_size) |-> (rd0_data == rd1_data));

endmodule

bind pfrf_top pfrf_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_dst_size(wr_dst_size),
    .wr_src_size(wr_src_size), .wr_sign(wr_sign), .wr_data(wr_data)
);

// File: tb/sim_pfrf_top.sv
module sim_pfrf_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rd0_idx, rd1_idx, wr_idx;
    logic [3:0]  rd0_size, rd1_size, wr_dst_size, wr_src_size;
    logic [63:0] rd0_data, rd1_data, wr_data;
    logic        wr_en, wr_sign;

    int checks = 0;
    int errs = 0;
    bit done = 0;
    logic [63:0] model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    pfrf_top u0 (
        .clk(clk), .rst(rst),
        .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_dst_size(wr_dst_size),
        .wr_src_size(wr_src_size), .wr_sign(wr_sign), .wr_data(wr_data)
    );

    function automatic int nbytes(input logic [3:0] s);
        if (s == 4'd1 || s == 4'd2 || s == 4'd4 || s == 4'd8) return int'(s);
        return 0;
    endfunction

    function automatic logic [63:0] ref_read(input logic [63:0] v, input logic [3:0] s);
        logic [63:0] r = '0;
        for (int i = 0; i < 8 * nbytes(s); i++) r[i] = v[i];
        return r;
    endfunction

    function automatic logic [63:0] ref_write(input logic [63:0] old, input logic [63:0] d,
                                              input logic [3:0] dst, input logic [3:0] src,
                                              input logic sx);
        logic [63:0] r;
        int dn = nbytes(dst);
        int sn = nbytes(src);
        if (dn == 0) return old;
        if (sn == 0 || sn >= dn) sn = dn;
        for (int i = 0; i < 64; i++) begin
            if (i < 8 * sn)      r[i] = d[i];
            else if (i < 8 * dn) r[i] = sx ? d[8*sn-1] : 1'b0;
            else if (dn == 4)    r[i] = 1'b0;
            else                 r[i] = old[i];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called one unit after a falling edge with inputs set.
    task automatic tick(input string req, input bit has_exp, input logic [63:0] exp);
        #2;
        chk(req, rd0_data, ref_read(model[rd0_idx], rd0_size));
        chk(req, rd1_data, ref_read(model[rd1_idx], rd1_size));
        if (has_exp) chk(req, rd0_data, exp);
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 16; i++) model[i] = '0;
        end else if (wr_en) begin
            model[wr_idx] = ref_write(model[wr_idx], wr_data, wr_dst_size, wr_src_size, wr_sign);
        end
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input string req, input logic [3:0] idx, input logic [3:0] dst,
                      input logic [3:0] src, input logic sx, input logic [63:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_dst_size = dst; wr_src_size = src;
        wr_sign = sx; wr_data = d;
        rd0_idx = idx; rd0_size = 4'd8; rd1_idx = idx; rd1_size = 4'd8;
        tick(req, 1'b0, '0);
        wr_en = 1'b0;
    endtask

    task automatic peek(input string req, input logic [3:0] idx, input logic [3:0] s,
                        input logic [63:0] exp);
        wr_en = 1'b0; rd0_idx = idx; rd0_size = s; rd1_idx = idx; rd1_size = s;
        tick(req, 1'b1, exp);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_dst_size = 4'd8; wr_src_size = 4'd8;
        wr_sign = 1'b0; wr_data = '0; rd0_idx = '0; rd1_idx = '0;
        rd0_size = 4'd8; rd1_size = 4'd8;
        @(negedge clk); #1;
        tick("R1", 1'b0, '0);
        tick("R1", 1'b0, '0);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) peek("R1", 4'(i), 4'd8, 64'd0);

        // R3 full write and aliased reads
        wr("R3", 4'd3, 4'd8, 4'd8, 1'b0, 64'h0011_2233_4455_6677);
        peek("R3", 4'd3, 4'd8, 64'h0011_2233_4455_6677);
        peek("R3", 4'd3, 4'd4, 64'h0000_0000_4455_6677);
        peek("R2", 4'd3, 4'd2, 64'h0000_0000_0000_6677);
        peek("R2", 4'd3, 4'd1, 64'h0000_0000_0000_0077);
        peek("R2", 4'd3, 4'd3, 64'd0);
        // R5 byte merge
        wr("R5", 4'd3, 4'd1, 4'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFAA);
        peek("R5", 4'd3, 4'd8, 64'h0011_2233_4455_66AA);
        // R4 dword clears top
        wr("R4", 4'd3, 4'd4, 4'd4, 1'b0, 64'h1234_5678_DEAD_BEEF);
        peek("R4", 4'd3, 4'd8, 64'h0000_0000_DEAD_BEEF);
        // R6 word dest with sign-extended byte keeps top
        wr("R6", 4'd4, 4'd8, 4'd8, 1'b0, 64'h1111_2222_3333_4444);
        wr("R6", 4'd4, 4'd2, 4'd1, 1'b1, 64'h0000_0000_0000_0080);
        peek("R6", 4'd4, 4'd8, 64'h1111_2222_3333_FF80);
        wr("R6", 4'd4, 4'd2, 4'd1, 1'b0, 64'h0000_0000_0000_00C1);
        peek("R6", 4'd4, 4'd8, 64'h1111_2222_3333_00C1);
        // R7 / R8 byte to quad
        wr("R7", 4'd5, 4'd8, 4'd1, 1'b0, 64'h5555_5555_5555_55AA);
        peek("R7", 4'd5, 4'd8, 64'h0000_0000_0000_00AA);
        wr("R8", 4'd5, 4'd8, 4'd1, 1'b1, 64'h5555_5555_5555_55AA);
        peek("R8", 4'd5, 4'd8, 64'hFFFF_FFFF_FFFF_FFAA);
        wr("R8", 4'd5, 4'd8, 4'd4, 1'b1, 64'h0000_0000_8000_0001);
        peek("R8", 4'd5, 4'd8, 64'hFFFF_FFFF_8000_0001);
        // R9 zero-extend dword to quad equals plain dword
        wr("R9", 4'd6, 4'd8, 4'd8, 1'b0, 64'hABCD_ABCD_ABCD_ABCD);
        wr("R9", 4'd7, 4'd8, 4'd8, 1'b0, 64'h9876_5432_1234_5678);
        wr("R9", 4'd6, 4'd8, 4'd4, 1'b0, 64'hFFFF_FFFF_8000_0001);
        wr("R9", 4'd7, 4'd4, 4'd4, 1'b0, 64'hFFFF_FFFF_8000_0001);
        peek("R9", 4'd6, 4'd8, 64'h0000_0000_8000_0001);
        peek("R9", 4'd7, 4'd8, 64'h0000_0000_8000_0001);
        // R10 wider or invalid source is a plain move
        wr("R10", 4'd8, 4'd8, 4'd8, 1'b0, 64'hCCCC_CCCC_CCCC_CCCC);
        wr("R10", 4'd8, 4'd1, 4'd8, 1'b1, 64'h0000_0000_0000_0081);
        peek("R10", 4'd8, 4'd8, 64'hCCCC_CCCC_CCCC_CC81);
        wr("R10", 4'd8, 4'd8, 4'd5, 1'b1, 64'h0000_0000_0000_0081);
        peek("R10", 4'd8, 4'd8, 64'h0000_0000_0000_0081);
        // R11 same-cycle read sees old value; disabled/invalid writes ignored
        wr_en = 1'b1; wr_idx = 4'd8; wr_dst_size = 4'd8; wr_src_size = 4'd8;
        wr_sign = 1'b0; wr_data = 64'h0F0F_0F0F_0F0F_0F0F;
        rd0_idx = 4'd8; rd0_size = 4'd8; rd1_idx = 4'd8; rd1_size = 4'd8;
        tick("R11", 1'b1, 64'h0000_0000_0000_0081);
        wr_en = 1'b0;
        peek("R11", 4'd8, 4'd8, 64'h0F0F_0F0F_0F0F_0F0F);
        wr_idx = 4'd8; wr_data = 64'h1; wr_dst_size = 4'd8; wr_src_size = 4'd8;
        rd0_idx = 4'd8; rd0_size = 4'd8; rd1_idx = 4'd9; rd1_size = 4'd8;
        tick("R11", 1'b0, '0);
        peek("R11", 4'd8, 4'd8, 64'h0F0F_0F0F_0F0F_0F0F);
        wr("R11", 4'd8, 4'd6, 4'd1, 1'b0, 64'h2);
        peek("R11", 4'd8, 4'd8, 64'h0F0F_0F0F_0F0F_0F0F);
        // R12 and everything: random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] codes [4] = '{4'd1, 4'd2, 4'd4, 4'd8};
            rst = ($urandom_range(0, 499) == 0);
            wr_en = $urandom_range(0, 3) != 0;
            wr_idx = 4'($urandom_range(0, 15));
            wr_dst_size = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15))
                                                      : codes[$urandom_range(0, 3)];
            wr_src_size = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15))
                                                      : codes[$urandom_range(0, 3)];
            wr_sign = 1'($urandom_range(0, 1));
            wr_data = {32'($urandom()), 32'($urandom())};
            rd0_idx = 4'($urandom_range(0, 15));
            rd1_idx = ($urandom_range(0, 3) == 0) ? rd0_idx : 4'($urandom_range(0, 15));
            rd0_size = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15))
                                                   : codes[$urandom_range(0, 3)];
            rd1_size = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15))
                                                   : codes[$urandom_range(0, 3)];
            tick("R12", 1'b0, '0);
        end
        rst = 1'b0; wr_en = 1'b0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule